// File: doc/BRIEF.md
# Buffered Word-Program Sequencer

This block runs the host side of a buffered program operation for a NOR flash array. The host opens the operation with a setup write (code E8h) at the first address it wants to program. An extended status register then shows whether the word buffer took the request. Next the host writes a word count encoded as N-1. It follows with N address/data writes to consecutive addresses, and ends with a confirm write (code D0h) at any address inside the target block.

When the confirm is valid and the external lock input reports the block unlocked, the sequencer replays the buffered words into a word-write port of the array. It writes one word per cycle in ascending address order, and the ready bit of the status register stays low until the last word has gone out. A malformed sequence or a locked block ends the operation early. In that case nothing is written and error bits are left in the status register for the host to read.

Blocks are aligned regions of 2^BLK_W words, so the block number is the address above bit BLK_W. The buffer holds DEPTH words, which is 16 by default.

Top module: `pbuf_prog_loader`

## Requirements
- R1: A setup write (data E8h) while the sequencer is idle starts an operation at the written address. It sets xstatus to 0x0080 (bit 7 high, all other bits zero) and clears status error bits 5, 4 and 1.
- R2: A setup write during a commit does not disturb the commit. It drives xstatus bit 7 to 0 until a later setup write is accepted.
- R3: The write after setup carries the word count minus one. A value above DEPTH-1 (15 by default) sets status bits 5 and 4, returns the sequencer to idle and writes nothing.
- R4: Each data write must target start address plus its position in the load. Any other address sets status bit 4 and aborts with nothing written.
- R5: A data address outside the block of the start address (block = address bits 21..15 by default) sets status bit 4 and aborts with nothing written.
- R6: A confirm write whose data is not D0h sets status bits 5 and 4 and writes nothing.
- R7: A confirm write at an address outside the start block sets status bit 4 and writes nothing.
- R8: If blk_locked is high at a valid confirm, status bits 1 and 4 are set and nothing is written.
- R9: After a valid confirm, the array port writes the N buffered words at start+0 .. start+N-1, one per cycle, in the cycles right after the confirm edge, with the data as loaded.
- R10: Status bit 7 is 0 while a commit runs and 1 otherwise. Status bits 15..8, 6, 3, 2 and 0 read 0.
- R11: Writes other than E8h while idle are ignored: status, xstatus and the array port stay unchanged.
- R12: Reset aborts any operation. After reset, status reads 0x0080, xstatus reads 0x0000 and arr_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Host write word address |
| wr_data | input | DATA_W | Host write data or command code |
| blk_locked | input | 1 | Lock state of the block addressed at confirm, from the lock block |
| status | output | 16 | Status register: bit 7 ready, 5 sequence error, 4 program error, 1 protect |
| xstatus | output | 16 | Extended status: bit 7 buffer available |
| arr_we | output | 1 | Array word-write strobe |
| arr_addr | output | ADDR_W | Array word-write address |
| arr_data | output | DATA_W | Array word-write data |

## Verification
On every cycle, the assertions check the following:
- Consecutive commit writes step the address by one.
- A commit ends exactly at start plus the loaded count.
- The load index never passes the announced count.
- An over-range count or a locked block produces the error bits with no array write.
- A setup write during a commit clears buffer availability.

Only the bench scenarios can show the rest:
- The committed data matches what was loaded.
- Each abort path (gap in the addresses, block crossing, wrong confirm code, confirm in a foreign block) writes nothing.
- Idle writes are ignored.
- Errors clear on the next accepted setup.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_LOAD,
    ST_CONFIRM,
    ST_COMMIT
  } pbl_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
endpackage

// File: rtl/pbl_rst_sync.sv
module pbl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pbl_word_buf.sv
module pbl_word_buf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic word_en;
    assign word_en = we && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (word_en) word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[idx];
endmodule

// File: rtl/pbl_seq_check.sv
module pbl_seq_check #(
  parameter int ADDR_W = 22,
  parameter int BLK_W  = 15,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] exp_addr,
  output logic              in_seq,
  output logic              same_blk
);
  assign exp_addr = start_addr + ADDR_W'(idx);
  assign in_seq   = (wr_addr == exp_addr);
  assign same_blk = (wr_addr[ADDR_W-1:BLK_W] == start_addr[ADDR_W-1:BLK_W]);
endmodule

// File: rtl/pbuf_prog_loader.sv
module pbuf_prog_loader
  import pbl_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int BLK_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              blk_locked,
  output logic [15:0]       status,
  output logic [15:0]       xstatus,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic rst_s;
  pbl_state_e state_q, state_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [IDX_W-1:0]  total_q, total_d, idx_q, idx_d;
  logic seq_err_q, seq_err_d, prg_err_q, prg_err_d, prot_q, prot_d;
  logic avail_q, avail_d;
  logic buf_we;
  logic [ADDR_W-1:0] exp_addr;
  logic in_seq, same_blk;
  logic is_setup, is_confirm, cnt_bad;

  pbl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s));

  pbl_seq_check #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_seq (
    .start_addr(start_q), .idx(idx_q), .wr_addr(wr_addr),
    .exp_addr(exp_addr), .in_seq(in_seq), .same_blk(same_blk)
  );

  pbl_word_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(buf_we), .idx(idx_q), .wdata(wr_data), .rdata(arr_data)
  );

  assign is_setup   = (wr_data == DATA_W'(CMD_SETUP));
  assign is_confirm = (wr_data == DATA_W'(CMD_CONFIRM));
  assign cnt_bad    = (wr_data > DATA_W'(DEPTH - 1));

  always_comb begin
    state_d   = state_q;
    start_d   = start_q;
    total_d   = total_q;
    idx_d     = idx_q;
    seq_err_d = seq_err_q;
    prg_err_d = prg_err_q;
    prot_d    = prot_q;
    avail_d   = avail_q;
    buf_we    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_en && is_setup) begin
          state_d   = ST_COUNT;
          start_d   = wr_addr;
          avail_d   = 1'b1;
          seq_err_d = 1'b0;
          prg_err_d = 1'b0;
          prot_d    = 1'b0;
        end
      end
      ST_COUNT: begin
        if (wr_en) begin
          if (cnt_bad) begin
            seq_err_d = 1'b1;
            prg_err_d = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            total_d = wr_data[IDX_W-1:0];
            idx_d   = '0;
            state_d = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (wr_en) begin
          if (!in_seq || !same_blk) begin
            prg_err_d = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            buf_we = 1'b1;
            if (idx_q == total_q) state_d = ST_CONFIRM;
            else                  idx_d   = idx_q + 1'b1;
          end
        end
      end
      ST_CONFIRM: begin
        if (wr_en) begin
          state_d = ST_IDLE;
          if (!is_confirm) begin
            seq_err_d = 1'b1;
            prg_err_d = 1'b1;
          end else if (!same_blk) begin
            prg_err_d = 1'b1;
          end else if (blk_locked) begin
            prot_d    = 1'b1;
            prg_err_d = 1'b1;
          end else begin
            idx_d   = '0;
            state_d = ST_COMMIT;
          end
        end
      end
      ST_COMMIT: begin
        if (wr_en && is_setup) avail_d = 1'b0;
        if (idx_q == total_q) state_d = ST_IDLE;
        else                  idx_d   = idx_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q   <= ST_IDLE;
      start_q   <= '0;
      total_q   <= '0;
      idx_q     <= '0;
      seq_err_q <= 1'b0;
      prg_err_q <= 1'b0;
      prot_q    <= 1'b0;
      avail_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      start_q   <= start_d;
      total_q   <= total_d;
      idx_q     <= idx_d;
      seq_err_q <= seq_err_d;
      prg_err_q <= prg_err_d;
      prot_q    <= prot_d;
      avail_q   <= avail_d;
    end
  end

  assign arr_we   = (state_q == ST_COMMIT);
  assign arr_addr = exp_addr;
  assign status   = {8'h00, !arr_we, 1'b0, seq_err_q, prg_err_q, 2'b00, prot_q, 1'b0};
  assign xstatus  = {8'h00, avail_q, 7'h00};

  // R9
  commit_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (arr_we && $past(arr_we)) |-> arr_addr == $past(arr_addr) + 1'b1);

  // R9
  commit_len_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(arr_we) |-> $past(arr_addr) == start_q + ADDR_W'(total_q));

  // R4
  load_bound_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_LOAD) |-> idx_q <= total_q);

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_COUNT && wr_en && cnt_bad) |=> (status[5:4] == 2'b11) && !arr_we);

  // R8
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_CONFIRM && wr_en && is_confirm && same_blk && blk_locked)
      |=> !arr_we && status[1] && status[4]);

  // R2
  busy_avail_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (arr_we && wr_en && is_setup) |=> !xstatus[7]);
endmodule

// File: tb/pbuf_prog_loader_tb_top.sv
module pbuf_prog_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic blk_locked = 1'b0;
  logic [15:0] status, xstatus, arr_data;
  logic [21:0] arr_addr;
  logic arr_we;

  int n_run = 0, n_fail = 0, nwr = 0;
  bit done = 1'b0;
  logic [15:0] exp_d [16];

  always #5 clk = ~clk;

  pbuf_prog_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_locked(blk_locked), .status(status), .xstatus(xstatus),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  always @(negedge clk) if (arr_we) nwr++;

  typedef struct packed {
    logic [21:0] start;
    logic [15:0] cnt;
    logic [1:0]  fault;  // 0 none, 1 address gap, 2 bad confirm code, 3 confirm in other block
    logic        lck;
    logic [7:0]  exp_sr;
    logic [4:0]  exp_nw;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{22'h000100, 16'd3,  2'd0, 1'b0, 8'h80, 5'd4},   // R9
    '{22'h3F8000, 16'd15, 2'd0, 1'b0, 8'h80, 5'd16},  // R9 full buffer
    '{22'h123450, 16'd0,  2'd0, 1'b0, 8'h80, 5'd1},   // R9 single word
    '{22'h000200, 16'd16, 2'd0, 1'b0, 8'hB0, 5'd0},   // R3
    '{22'h010000, 16'd5,  2'd1, 1'b0, 8'h90, 5'd0},   // R4
    '{22'h007FF8, 16'd15, 2'd0, 1'b0, 8'h90, 5'd0},   // R5
    '{22'h020000, 16'd2,  2'd2, 1'b0, 8'hB0, 5'd0},   // R6
    '{22'h030000, 16'd2,  2'd3, 1'b0, 8'h90, 5'd0},   // R7
    '{22'h040000, 16'd7,  2'd0, 1'b1, 8'h92, 5'd0}    // R8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] dval(input logic [21:0] s, input int i);
    return s[15:0] ^ 16'(i * 16'h0101) ^ 16'h5A00;
  endfunction

  task automatic run_vec(input vec_t v);
    int nw0 = nwr;
    bit aborted;
    logic [21:0] a;
    blk_locked = v.lck;
    hwrite(v.start, 16'h00E8);
    chk(xstatus == 16'h0080, "R1", xstatus, 16'h0080);
    chk(status == 16'h0080, "R1", status, 16'h0080);
    hwrite(v.start, v.cnt);
    aborted = (v.cnt > 16'd15);
    if (!aborted) begin
      for (int i = 0; i <= int'(v.cnt); i++) begin
        a = v.start + 22'(i);
        if (v.fault == 2'd1 && i == 1) a = a + 1'b1;
        exp_d[i] = dval(v.start, i);
        hwrite(a, exp_d[i]);
        if (a[21:15] != v.start[21:15] || (v.fault == 2'd1 && i == 1)) begin
          aborted = 1'b1;
          break;
        end
      end
    end
    if (!aborted) begin
      a = (v.fault == 2'd3) ? {v.start[21:15] + 7'd1, 15'h0000} : {v.start[21:15], 15'h7ABC};
      hwrite(a, (v.fault == 2'd2) ? 16'h00D1 : 16'h00D0);
      for (int i = 0; i < int'(v.exp_nw); i++) begin
        chk(arr_we && arr_addr == v.start + 22'(i) && arr_data == exp_d[i], "R9",
            {arr_we, arr_addr[14:0], arr_data}, {1'b1, 15'(v.start + 22'(i)), exp_d[i]});
        chk(status[7] == 1'b0, "R10", status, 16'h0000);
        @(negedge clk);
      end
    end
    chk(status == {8'h00, v.exp_sr}, "R3/R4/R5/R6/R7/R8 status", status, {8'h00, v.exp_sr});
    chk(nwr - nw0 == int'(v.exp_nw), "R9 write count", nwr - nw0, v.exp_nw);
    blk_locked = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    int nw0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(status == 16'h0080, "R12", status, 16'h0080);
    chk(xstatus == 16'h0000, "R12", xstatus, 16'h0000);
    chk(arr_we == 1'b0, "R12", arr_we, 0);

    foreach (VECS[k]) run_vec(VECS[k]);

    // R2: setup write during a commit
    nw0 = nwr;
    hwrite(22'h050000, 16'h00E8);
    hwrite(22'h050000, 16'd15);
    for (int i = 0; i < 16; i++) hwrite(22'h050000 + 22'(i), dval(22'h050000, i));
    hwrite(22'h050123, 16'h00D0);
    hwrite(22'h000000, 16'h00E8);
    chk(xstatus == 16'h0000, "R2", xstatus, 16'h0000);
    chk(status[7] == 1'b0, "R10", status, 16'h0000);
    w = 0;
    while (status[7] == 1'b0 && w < 40) begin @(negedge clk); w++; end
    chk(nwr - nw0 == 16, "R2 commit intact", nwr - nw0, 16);
    chk(xstatus == 16'h0000, "R2 held", xstatus, 16'h0000);
    hwrite(22'h060000, 16'h00E8);
    chk(xstatus == 16'h0080, "R1", xstatus, 16'h0080);

    // R3 leaves sequencer idle with errors; R11 idle writes ignored
    hwrite(22'h060000, 16'h0020);
    chk(status == 16'h00B0, "R3", status, 16'h00B0);
    nw0 = nwr;
    hwrite(22'h060000, 16'h0040);
    hwrite(22'h060001, 16'h00D0);
    chk(status == 16'h00B0, "R11", status, 16'h00B0);
    chk(xstatus == 16'h0080, "R11", xstatus, 16'h0080);
    chk(nwr == nw0, "R11", nwr - nw0, 0);
    hwrite(22'h060000, 16'h00E8);
    chk(status == 16'h0080, "R1 clear", status, 16'h0080);

    // R12 reset mid-load
    hwrite(22'h060000, 16'd3);
    hwrite(22'h060000, 16'h1234);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(status == 16'h0080, "R12", status, 16'h0080);
    chk(xstatus == 16'h0000, "R12", xstatus, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    nw0 = nwr;
    hwrite(22'h060001, 16'h5555);
    hwrite(22'h060002, 16'h00D0);
    chk(nwr == nw0 && status == 16'h0080, "R12 idle after reset", status, 16'h0080);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule